// File: doc/BRIEF.md
# Low-Power PWM Timer with Handshaked Registers

This block is a single-channel pulse-width modulator that a host sets up through a small synchronous register port. A power-of-two prescaler turns the system clock into slow counting ticks. A 16-bit up-counter counts those ticks from zero to a reload value and then wraps. The output is driven active while the counter is above a compare value, and a polarity bit picks which level counts as active.

The register rules follow a slow counting domain. The configuration register, which holds the prescaler exponent and the polarity bit, can only be changed while the timer is disabled. The reload and compare registers can only be written while it is enabled. Each accepted reload or compare write passes through a two-tick synchronising handshake, and at the end of it a sticky OK flag is set. Software clears that flag by writing a one to the clear register. New reload and compare values reach the counter at its next wrap. Counting starts only when the start bit is set while the timer is already enabled.

Three state machines control the block. The run machine in the core has these states and transitions:
- `ST_OFF` goes to `ST_ARMED` when enable rises.
- `ST_ARMED` goes to `ST_RUN` when start is seen, and goes back to `ST_OFF` if enable drops.
- `ST_RUN` goes to `ST_OFF` when enable drops.

Each of the two write handshakes has these states and transitions:
- `HS_IDLE` goes to `HS_WAIT1` on an accepted write.
- `HS_WAIT1` goes to `HS_WAIT2` on a tick.
- `HS_WAIT2` goes back to `HS_IDLE` on a tick and signals completion.
- Any state goes to `HS_WAIT1` on a fresh write, and to `HS_IDLE` when the timer is disabled.

Top module: `lp_pwm_timer`

## Requirements
- R1: After reset, every readable register reads 0 and `pwm_out` is 0. The address map is: control at 0 (bit0 enable, bit1 start), configuration at 1 (bits 2:0 prescaler exponent, bit3 polarity), reload at 2, compare at 3, status at 4 (bit0 reload OK, bit1 compare OK), clear at 5.
- R2: A configuration write lands only while enable is 0. A configuration write made while enabled leaves the register unchanged.
- R3: Reload and compare writes land only while enable is 1. Writes made while disabled are ignored. Both registers read back their full 16 bits.
- R4: An accepted reload or compare write sets its status OK flag on the second prescaled tick after the write, and not before.
- R5: Writing 1 to clear bit0 or bit1 clears the matching OK flag. Writing 0 leaves it unchanged.
- R6: While running, one output period lasts reload+1 ticks, and one tick lasts 2^exponent clock cycles (exponent 0 to 7, ratio 1 to 128).
- R7: With polarity 0, the output is high for reload minus compare ticks per period, namely while the counter is above the compare value.
- R8: With polarity 1, the waveform is inverted, so the high phase lasts compare+1 ticks.
- R9: While disabled, or enabled but not started, the output holds its inactive level, which is equal to the polarity bit.
- R10: Reload and compare values written while running take effect at the next counter wrap.
- R11: Writing enable 0 stops the counter and clears both control bits.
- R12: The start bit is accepted only when the timer is already enabled. A start written together with enable from the disabled state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, registered on the edge that samples rd_en |
| pwm_out | output | 1 | Waveform output |

## Verification
The hardest situation to reach is a reload and compare update that lands in the middle of a running period. From the ports, only the waveform shows when the new values take hold. The stimulus writes new values while the counter runs, discards the first period it measures, and checks the next full period against the new reload and compare. The handshake flags are a second difficulty. The bench reads status straight after a write, using a divided tick so the flag cannot yet be set, and reads it again after enough cycles for two ticks to pass.

// File: rtl/lp_pwm_pkg.sv
package lp_pwm_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int EXP_W  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG    = 3'd1;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP    = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd4;
    localparam logic [ADDR_W-1:0] A_CLR    = 3'd5;

    typedef enum logic [1:0] {ST_OFF, ST_ARMED, ST_RUN} run_state_t;
    typedef enum logic [1:0] {HS_IDLE, HS_WAIT1, HS_WAIT2} hs_state_t;
endpackage

// File: rtl/lp_pwm_prescaler.sv
module lp_pwm_prescaler #(
    parameter int EXP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [EXP_W-1:0] exponent,
    output logic             tick
);
    localparam int DIV_W = (1 << EXP_W) - 1;

    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = DIV_W'((32'd1 << exponent) - 32'd1);
        tick = run && ((pcnt & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pcnt <= '0;
        else if (run) pcnt <= pcnt + 1'b1;
        else          pcnt <= '0;
    end
endmodule

// File: rtl/lp_pwm_wsync.sv
module lp_pwm_wsync
    import lp_pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic wr,
    input  logic tick,
    output logic done
);
    hs_state_t st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= HS_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (!run) st_nx = HS_IDLE;
        else if (wr) st_nx = HS_WAIT1;
        else begin
            unique case (st)
                HS_IDLE:  st_nx = HS_IDLE;
                HS_WAIT1: if (tick) st_nx = HS_WAIT2;
                HS_WAIT2: if (tick) st_nx = HS_IDLE;
                default:  st_nx = HS_IDLE;
            endcase
        end
    end

    always_comb begin
        done = run && !wr && (st == HS_WAIT2) && tick;
    end
endmodule

// File: rtl/lp_pwm_regs.sv
module lp_pwm_regs
    import lp_pwm_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int EW = EXP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          tick,
    output logic          en,
    output logic          start,
    output logic [EW-1:0] exponent,
    output logic          pol,
    output logic [DW-1:0] reload,
    output logic [DW-1:0] compare
);
    localparam int NSYNC = 2;

    logic [NSYNC-1:0] wr_ok;
    logic [NSYNC-1:0] done;
    logic [NSYNC-1:0] flag;

    always_comb begin
        wr_ok[0] = wr_en && (addr == A_RELOAD) && en;
        wr_ok[1] = wr_en && (addr == A_CMP) && en;
    end

    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        lp_pwm_wsync u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (en),
            .wr   (wr_ok[g]),
            .tick (tick),
            .done (done[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    flag[g] <= 1'b0;
            else if (done[g])                              flag[g] <= 1'b1;
            else if (wr_en && addr == A_CLR && wr_data[g]) flag[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en       <= 1'b0;
            start    <= 1'b0;
            exponent <= '0;
            pol      <= 1'b0;
            reload   <= '0;
            compare  <= '0;
        end else if (wr_en) begin
            unique case (addr)
                A_CTRL: begin
                    if (!wr_data[0]) begin
                        en    <= 1'b0;
                        start <= 1'b0;
                    end else begin
                        en    <= 1'b1;
                        start <= start | (en & wr_data[1]);
                    end
                end
                A_CFG: if (!en) begin
                    exponent <= wr_data[EW-1:0];
                    pol      <= wr_data[EW];
                end
                A_RELOAD: if (en) reload  <= wr_data;
                A_CMP:    if (en) compare <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) begin
            unique case (addr)
                A_CTRL:   rd_data <= DW'({start, en});
                A_CFG:    rd_data <= DW'({pol, exponent});
                A_RELOAD: rd_data <= reload;
                A_CMP:    rd_data <= compare;
                A_STAT:   rd_data <= DW'(flag);
                default:  rd_data <= '0;
            endcase
        end
    end

    assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) |-> ($stable(exponent) && $stable(pol)));

    assert_reload_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(reload) && $stable(compare)));

    assert_ok_after_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[0]) |-> $past(done[0]));

    assert_start_needs_en_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> en);
endmodule

// File: rtl/lp_pwm_core.sv
module lp_pwm_core
    import lp_pwm_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          start,
    input  logic          tick,
    input  logic          pol,
    input  logic [DW-1:0] reload,
    input  logic [DW-1:0] compare,
    output logic          pwm_out
);
    run_state_t st, st_nx;
    logic [DW-1:0] cnt;
    logic [DW-1:0] arr_act;
    logic [DW-1:0] cmp_act;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_OFF:   if (en) st_nx = ST_ARMED;
            ST_ARMED: if (!en) st_nx = ST_OFF;
                      else if (start) st_nx = ST_RUN;
            ST_RUN:   if (!en) st_nx = ST_OFF;
            default:  st_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            arr_act <= '0;
            cmp_act <= '0;
        end else if (st == ST_ARMED && st_nx == ST_RUN) begin
            cnt     <= '0;
            arr_act <= reload;
            cmp_act <= compare;
        end else if (st == ST_RUN && en && tick) begin
            if (cnt >= arr_act) begin
                cnt     <= '0;
                arr_act <= reload;
                cmp_act <= compare;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (st_nx == ST_OFF) begin
            cnt <= '0;
        end
    end

    always_comb begin
        pwm_out = pol ^ ((st == ST_RUN) && (cnt > cmp_act));
    end

    assert_idle_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_RUN) |-> (pwm_out == pol));

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |-> (cnt <= arr_act));

    assert_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st == ST_OFF));

    assert_wrap_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && $past(st) == ST_RUN && !$stable(arr_act)) |-> (cnt == '0));
endmodule

// File: rtl/lp_pwm_timer.sv
module lp_pwm_timer
    import lp_pwm_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int EW = EXP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          pwm_out
);
    logic          tick;
    logic          en;
    logic          start;
    logic [EW-1:0] exponent;
    logic          pol;
    logic [DW-1:0] reload;
    logic [DW-1:0] compare;

    lp_pwm_regs #(.AW(AW), .DW(DW), .EW(EW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .tick    (tick),
        .en      (en),
        .start   (start),
        .exponent(exponent),
        .pol     (pol),
        .reload  (reload),
        .compare (compare)
    );

    lp_pwm_prescaler #(.EXP_W(EW)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (en),
        .exponent(exponent),
        .tick    (tick)
    );

    lp_pwm_core #(.DW(DW)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .start  (start),
        .tick   (tick),
        .pol    (pol),
        .reload (reload),
        .compare(compare),
        .pwm_out(pwm_out)
    );
endmodule

// File: tb/test_lp_pwm_timer.sv
`timescale 1ns/1ps
module test_lp_pwm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_issued = 1'b0;

    always #2.5 clk = ~clk;

    lp_pwm_timer i_lp_pwm_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_en  (rd_en),
        .rd_data(rd_data),
        .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    always @(posedge clk) rd_issued <= rd_en;

    always @(negedge clk) begin
        if (rd_issued && exp_q.size() > 0) begin
            automatic logic [15:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(rd_data == e, t, int'(rd_data), int'(e));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic measure(output int hi, output int per);
        int lo;
        bit prev;
        prev = pwm_out;
        forever begin
            @(negedge clk);
            if (!prev && pwm_out) break;
            prev = pwm_out;
        end
        hi = 1;
        forever begin
            @(negedge clk);
            if (pwm_out) hi++; else break;
        end
        lo = 1;
        forever begin
            @(negedge clk);
            if (!pwm_out) lo++; else break;
        end
        per = hi + lo;
    endtask

    task automatic hold_level(input bit lvl, input int n, input string tag);
        bit ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out !== lvl) ok = 1'b0;
        end
        check(ok, tag, int'(pwm_out), int'(lvl));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int hi, per;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(pwm_out == 1'b0, "R1 pwm after reset", int'(pwm_out), 0);
        rd(3'd0, 16'd0, "R1 ctrl reset");
        rd(3'd1, 16'd0, "R1 cfg reset");
        rd(3'd2, 16'd0, "R1 reload reset");
        rd(3'd3, 16'd0, "R1 compare reset");
        rd(3'd4, 16'd0, "R1 status reset");

        // R3 writes while disabled are ignored
        wr(3'd2, 16'd5);
        wr(3'd3, 16'd2);
        rd(3'd2, 16'd0, "R3 reload ignored when disabled");
        rd(3'd3, 16'd0, "R3 compare ignored when disabled");

        // R2 config lands while disabled: exponent 1, polarity 0
        wr(3'd1, 16'h0001);
        rd(3'd1, 16'h0001, "R2 cfg written while disabled");

        // R12 start with enable from disabled is ignored
        wr(3'd0, 16'h0003);
        rd(3'd0, 16'h0001, "R12 start ignored from disabled");
        hold_level(1'b0, 30, "R9 inactive while armed");

        // R2 config write while enabled is ignored
        wr(3'd1, 16'h000B);
        rd(3'd1, 16'h0001, "R2 cfg locked while enabled");

        // R4 handshake timing, R3 readback
        wr(3'd2, 16'd9);
        rd(3'd4, 16'd0, "R4 reload flag not yet set");
        wr(3'd3, 16'd3);
        repeat (12) @(negedge clk);
        rd(3'd4, 16'd3, "R4 both flags set after two ticks");
        rd(3'd2, 16'd9, "R3 reload readback");
        rd(3'd3, 16'd3, "R3 compare readback");

        // R5 write-one-to-clear
        wr(3'd5, 16'd0);
        rd(3'd4, 16'd3, "R5 clear with zero keeps flags");
        wr(3'd5, 16'd1);
        rd(3'd4, 16'd2, "R5 clear reload flag only");
        wr(3'd5, 16'd2);
        rd(3'd4, 16'd0, "R5 clear compare flag");

        // R6 R7 start and measure: exponent 1, reload 9, compare 3
        wr(3'd0, 16'h0003);
        rd(3'd0, 16'h0003, "R12 start accepted when enabled");
        measure(hi, per);
        check(per == 20, "R6 period (9+1)*2", per, 20);
        check(hi == 12, "R7 high time (9-3)*2", hi, 12);

        // R10 update while running, effective at wrap
        wr(3'd2, 16'd4);
        wr(3'd3, 16'd1);
        measure(hi, per);
        measure(hi, per);
        check(per == 10, "R10 new period (4+1)*2", per, 10);
        check(hi == 6, "R10 new high time (4-1)*2", hi, 6);

        // R11 disable stops and clears control
        wr(3'd0, 16'h0000);
        rd(3'd0, 16'h0000, "R11 control cleared");
        hold_level(1'b0, 40, "R11 output idle after stop");

        // R8 polarity 1, exponent 0
        wr(3'd1, 16'h0008);
        rd(3'd1, 16'h0008, "R2 cfg polarity write");
        hold_level(1'b1, 10, "R9 inactive level high with polarity 1");
        wr(3'd0, 16'h0001);
        wr(3'd2, 16'd4);
        wr(3'd3, 16'd1);
        wr(3'd0, 16'h0003);
        measure(hi, per);
        check(per == 5, "R8 period (4+1)*1", per, 5);
        check(hi == 2, "R8 inverted high time 1+1", hi, 2);

        // R6 maximum ratio 128
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0007);
        wr(3'd0, 16'h0001);
        wr(3'd2, 16'd1);
        wr(3'd3, 16'd0);
        wr(3'd0, 16'h0003);
        measure(hi, per);
        check(per == 256, "R6 period at ratio 128", per, 256);
        check(hi == 128, "R7 high time at ratio 128", hi, 128);
        rd(3'd4, 16'd3, "R4 flags set with slow ticks");

        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule